// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fixed reference clock into a one-cycle enable pulse at sixteen times the line baud rate. Software works out an integer divisor, the reference clock over sixteen times the baud rate, and a 6-bit fraction, the remainder of that division expressed in 64ths and rounded to the nearest 64th. It writes the two parts into separate registers, one after the other, and then writes a commit. The block loads both parts only when it sees the commit, so a half-written divisor never reaches the tick.

Between ticks the block counts whole reference clocks. A 6-bit phase accumulator adds the fraction once per tick period. Each time the accumulator wraps, the next period is one clock longer. The average tick period therefore equals the programmed fractional divisor exactly, even when that value falls between two whole clock counts. A zero integer part, or an integer part of one with a nonzero fraction, cannot be realised, and the block then stays silent.

Top module: `frac_baud_tick`

## Requirements
- R1: After reset, `tick` stays low until the first `commit`, whatever values sit on the divisor inputs.
- R2: When `commit` is high in cycle c with a valid divisor of integer part N, the first `tick` is high in cycle c+N.
- R3: `tick` is high for one cycle at a time whenever the committed integer part is above one.
- R4: With integer part N and fraction F committed in cycle c, tick number k (counting from 0) falls in cycle c + (k+1)·N + floor(k·F/64). Every period is N or N+1 clocks, and the first period is never stretched.
- R5: Across any 64 consecutive tick periods, the total is exactly 64·N + F reference clocks.
- R6: An integer part of 0 at commit stops all ticks until the next commit.
- R7: An integer part of 1 with a nonzero fraction at commit produces no ticks. An integer part of 1 with fraction 0 ticks on every cycle.
- R8: Changes on `intDivIn` or `fracDivIn` without a `commit` have no effect on the tick schedule.
- R9: A `commit` while ticks are running restarts the schedule from R4 at the new commit cycle, with the accumulator cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intDivIn | input | 16 | Integer part of the divisor, held by the register file |
| fracDivIn | input | 6 | Fraction of the divisor in 64ths, held by the register file |
| commit | input | 1 | One-cycle strobe that loads both divisor parts |
| tick | output | 1 | One-cycle 16x oversampling enable |

## Verification
Assertions check on every cycle that the counter never exceeds the committed integer part plus one, that a tick is never followed by another when the period is above one, that a commit of a valid divisor above one is not followed by an immediate tick, and that committing either invalid divisor leaves the tick low. Only the bench's scenarios can show the exact placement of every stretched period, the exact 64-period span, the restart on a commit taken mid-schedule, and that register writes without a commit are ignored. Each of these is compared against tick times worked out from the closed-form schedule.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch new divisor, clear accumulator, start first period
    logic reload;   // period ended: start the next one, advance the accumulator
    logic countEn;  // decrement the period counter
  } dpCtrl_t;
endpackage

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [INT_W-1:0]  intDivIn,
  input  logic [FRAC_W-1:0] fracDivIn,
  output logic              terminal,
  output logic [INT_W-1:0]  actIntOut
);
  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0]  actInt;
  logic [FRAC_W-1:0] actFrac;
  logic [FRAC_W-1:0] phaseAcc;
  logic [CNT_W-1:0]  remain;
  logic [FRAC_W:0]   phaseSum;
  logic              stretch;
  logic [CNT_W-1:0]  nextLen;

  assign phaseSum = {1'b0, phaseAcc} + {1'b0, actFrac};
  assign stretch  = phaseSum[FRAC_W];
  assign nextLen  = {1'b0, actInt} + CNT_W'(stretch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actInt   <= '0;
      actFrac  <= '0;
      phaseAcc <= '0;
      remain   <= '0;
    end else if (ctrl.load) begin
      actInt   <= intDivIn;
      actFrac  <= fracDivIn;
      phaseAcc <= '0;
      remain   <= {1'b0, intDivIn};
    end else if (ctrl.reload) begin
      phaseAcc <= phaseSum[FRAC_W-1:0];
      remain   <= nextLen;
    end else if (ctrl.countEn && remain > CNT_W'(1)) begin
      remain   <= remain - CNT_W'(1);
    end
  end

  assign terminal  = (remain == CNT_W'(1));
  assign actIntOut = actInt;

  // R4: a period is never longer than the integer part plus one clock
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    remain <= ({1'b0, actInt} + CNT_W'(1)))
    else $error("period counter above integer part plus one");
endmodule

// File: rtl/baud_tick_ctl.sv
module baud_tick_ctl
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commit,
  input  logic [INT_W-1:0]  intDivIn,
  input  logic [FRAC_W-1:0] fracDivIn,
  input  logic              terminal,
  output dpCtrl_t           ctrl,
  output logic              tick
);
  logic runQ;
  logic divOk;

  // A zero integer part, or one with a nonzero fraction, is unrealisable
  assign divOk = (intDivIn != '0) &&
                 !((intDivIn == INT_W'(1)) && (fracDivIn != '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       runQ <= 1'b0;
    else if (commit) runQ <= divOk;
  end

  assign tick         = runQ && terminal;
  assign ctrl.load    = commit;
  assign ctrl.reload  = tick && !commit;
  assign ctrl.countEn = runQ && !commit;

  // R6: committing a zero integer part silences the tick
  assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (commit && intDivIn == '0) |=> !tick)
    else $error("tick after zero divisor commit");

  // R7: integer part one with a fraction is rejected
  assert_unit_frac_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (commit && intDivIn == INT_W'(1) && fracDivIn != '0) |=> !tick)
    else $error("tick after invalid unit divisor commit");
endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  intDivIn,
  input  logic [FRAC_W-1:0] fracDivIn,
  input  logic              commit,
  output logic              tick
);
  dpCtrl_t          ctrl;
  logic             terminal;
  logic [INT_W-1:0] actInt;

  baud_tick_ctl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ctl (
    .clk(clk), .rstN(rstN), .commit(commit),
    .intDivIn(intDivIn), .fracDivIn(fracDivIn),
    .terminal(terminal), .ctrl(ctrl), .tick(tick)
  );

  baud_tick_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .intDivIn(intDivIn), .fracDivIn(fracDivIn),
    .terminal(terminal), .actIntOut(actInt)
  );

  // R3: with a period above one, a tick is a single-cycle pulse
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !commit && actInt > INT_W'(1)) |=> !tick)
    else $error("tick held for two cycles");

  // R2: the first period after a commit is a full period, never immediate
  assert_first_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (commit && intDivIn > INT_W'(1)) |=> !tick)
    else $error("tick immediately after commit");
endmodule

// File: tb/test_frac_baud_tick.sv
module test_frac_baud_tick;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] intDivIn = '0;
  logic [5:0]  fracDivIn = '0;
  logic        commit = 1'b0;
  logic        tick;

  int nChecks = 0;
  int nFails  = 0;
  longint cycleCount = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  frac_baud_tick i_frac_baud_tick (
    .clk(clk), .rstN(rstN), .intDivIn(intDivIn), .fracDivIn(fracDivIn),
    .commit(commit), .tick(tick)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected cycle (relative to the commit cycle) of tick number k
  function automatic longint expTickAt(longint k, int iv, int fv);
    return (k + 1) * iv + (k * fv) / 64;
  endfunction

  function automatic bit divValid(int iv, int fv);
    return (iv != 0) && !(iv == 1 && fv != 0);
  endfunction

  task automatic runDiv(int iv, int fv, int window, bit disturb, string schedReq);
    bit     ok;
    longint k, tNext, badT, firstT, t0, t64, nTicks;
    bit     badAct;
    ok = divValid(iv, fv);
    @(negedge clk);
    intDivIn  = 16'(iv);
    fracDivIn = 6'(fv);
    commit    = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    k = 0; tNext = expTickAt(0, iv, fv);
    badT = -1; badAct = 1'b0; firstT = -1; t0 = -1; t64 = -1; nTicks = 0;
    for (int t = 1; t <= window; t++) begin
      bit expT;
      expT = ok && (t == tNext);
      if (tick) begin
        nTicks++;
        if (firstT < 0) firstT = t;
        if (nTicks == 1)  t0 = t;
        if (nTicks == 65) t64 = t;
      end
      if (tick != expT && badT < 0) begin badT = t; badAct = tick; end
      if (expT) begin k++; tNext = expTickAt(k, iv, fv); end
      if (disturb && t == window / 2) begin
        intDivIn  = 16'($urandom);
        fracDivIn = 6'($urandom);
      end
      @(negedge clk);
    end
    check(badT < 0, schedReq, $sformatf("tick schedule N=%0d F=%0d cycle %0d", iv, fv, badT),
          longint'(badAct), longint'(!badAct));
    if (ok) begin
      check(firstT == iv, "R2", $sformatf("first tick cycle N=%0d F=%0d", iv, fv),
            firstT, iv);
      if (window >= 66 * iv + 64)
        check(t64 >= 0 && (t64 - t0) == 64 * iv + fv, "R5",
              $sformatf("64-period span N=%0d F=%0d", iv, fv), t64 - t0, 64 * iv + fv);
    end else begin
      check(nTicks == 0, (iv == 0) ? "R6" : "R7",
            $sformatf("ticks for invalid N=%0d F=%0d", iv, fv), nTicks, 0);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 190000) begin
        nFails++;
        nChecks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycleCount);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin : stimulus
    int seen;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: quiet after reset, inputs set but nothing committed
    intDivIn = 16'd3; fracDivIn = 6'd7;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R1", "ticks before first commit", seen, 0);

    // Directed corners
    runDiv(1, 0, 200, 1'b0, "R7");      // tick every cycle
    runDiv(2, 0, 200, 1'b0, "R3");
    runDiv(2, 63, 400, 1'b0, "R4");     // stretch on almost every period
    runDiv(3, 1, 400, 1'b0, "R4");      // single stretch per 64
    runDiv(1, 5, 300, 1'b0, "R7");      // invalid
    runDiv(0, 0, 300, 1'b0, "R6");      // stopped
    runDiv(0, 40, 300, 1'b0, "R6");
    runDiv(5, 32, 500, 1'b1, "R8");     // inputs disturbed without commit
    runDiv(7, 19, 123, 1'b0, "R4");     // cut short ...
    runDiv(4, 45, 400, 1'b0, "R9");     // ... then restart mid-schedule
    runDiv(6, 50, 37, 1'b0, "R4");
    runDiv(6, 50, 500, 1'b0, "R9");

    // Random divisors
    for (int r = 0; r < 12; r++) begin
      int iv, fv;
      iv = 2 + int'($urandom % 30);
      fv = int'($urandom % 64);
      runDiv(iv, fv, 66 * iv + 80, (r % 3) == 0, ((r % 3) == 0) ? "R8" : "R4");
    end

    // Largest integer part: first tick only
    runDiv(65535, 0, 65540, 1'b0, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule